// File: doc/BRIEF.md
# Automatic Channel/Gain Scan Sequencer

This block keeps a short table of scan entries loaded by the host. Each entry names an analog input channel, a two-bit gain code and two reference flags: one for a half-gain stage and one for unipolar operation with an offset. While acquisition is enabled, every conversion strobe from the conversion controller moves the block to the next entry. After the last valid entry it returns to entry 0, so the table is replayed in order for as long as acquisition runs.

For the selected entry, the block drives the external multiplexer select, the amplifier gain select and the two reference lines from registers. These lines change on the same clock edge that accepts a strobe, so they are settled before the next conversion begins. A configuration input chooses single-ended or differential wiring. In differential mode only the lower three channel bits reach the multiplexer. The active configuration is reported back on a status output. A length register sets how many table entries take part in the cycle.

Top module: `scan_seq_top`

## Requirements
- R1: After reset the entry index is 0, all select outputs are 0 and the cycle length is 1, so strobes while acquiring keep the index at 0.
- R2: While acq_en is low, adv strobes have no effect and cur_idx stays 0.
- R3: With acq_en high, an adv strobe on a clock edge moves cur_idx to the next entry on that edge. The select outputs show the stored fields of the new entry from that edge on. Without a strobe the index holds.
- R4: A strobe taken at index length-1, or at any index at or above the current length, returns cur_idx to 0.
- R5: A written length of 0 pins the index at entry 0. A written length above DEPTH is stored as DEPTH.
- R6: In single-ended mode mux_sel equals entry bits [3:0]. In differential mode mux_sel[3] is driven 0 and bits [2:0] follow the entry.
- R7: gain_sel follows entry bits [5:4] (codes 0..3 mean gain 1, 2, 4, 8). ref_half follows bit 6 (0.5x stage) and ref_uni follows bit 7 (unipolar with offset).
- R8: se_status is 1 when diff_mode is 0 (single-ended) and 0 otherwise.
- R9: A write to an entry changes only that entry. If it is the entry currently selected, the outputs show the new value one cycle after the write.
- R10: Dropping acq_en returns cur_idx to 0 on the next edge, so a later run restarts at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table entry |
| wr_addr | input | 4 | Entry address |
| wr_data | input | 8 | Entry value {uni, half, gain[1:0], chan[3:0]} |
| len_we | input | 1 | Write the cycle length |
| len_data | input | 5 | Cycle length, saturated at DEPTH |
| diff_mode | input | 1 | 1 = differential wiring |
| acq_en | input | 1 | Acquisition active |
| adv | input | 1 | Per-conversion advance strobe |
| cur_idx | output | 4 | Index of the selected entry |
| mux_sel | output | 4 | Multiplexer channel select |
| gain_sel | output | 2 | Gain code |
| ref_half | output | 1 | 0.5x stage select |
| ref_uni | output | 1 | Unipolar/offset select |
| se_status | output | 1 | 1 = single-ended configuration |

## Verification
The bench builds the block with the default DEPTH of 16. This covers the full four-bit channel range, the saturation of an out-of-range length written through the five-bit length port, and a complete wrap over all sixteen entries. Random runs mix writes to the table and the length with strobes and mode changes while acquisition is running. This covers length shrinks that leave the index above the new length, and writes that hit the selected entry.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int CH_W   = 4;
  localparam int GAIN_W = 2;

  // Field order matches the write-data layout.
  typedef struct packed {
    logic              uni;
    logic              half;
    logic [GAIN_W-1:0] gain;
    logic [CH_W-1:0]   ch;
  } scan_entry_t;

  localparam int ENTRY_W = $bits(scan_entry_t);
endpackage

// File: rtl/scan_seq_mem.sv
module scan_seq_mem
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  scan_entry_t      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output scan_entry_t      rd_data
);

  scan_entry_t tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    scan_entry_t ent_q;
    logic        ent_en;

    assign ent_en = wr_en && (wr_addr == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= wr_data;
      end
    end

    assign tab[g] = ent_q;
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < DEPTH) begin
      rd_data = tab[rd_idx];
    end
  end

endmodule

// File: rtl/scan_seq_ptr.sv
module scan_seq_ptr #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_en,
  input  logic             adv,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_data,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_nxt,
  output logic [LEN_W-1:0] len_q
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);

  logic [LEN_W-1:0] len_nxt;
  logic [LEN_W-1:0] idx_inc;

  always_comb begin
    len_nxt = len_q;
    if (len_we) begin
      len_nxt = (len_data > LEN_MAX) ? LEN_MAX : len_data;
    end
  end

  always_comb begin
    idx_inc = LEN_W'(idx_q) + LEN_W'(1);
    idx_nxt = idx_q;
    if (!acq_en) begin
      idx_nxt = '0;
    end else if (adv) begin
      // A length of 0 also lands here, so the index stays at 0.
      idx_nxt = (idx_inc >= len_q) ? '0 : IDX_W'(idx_inc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      len_q <= LEN_W'(1);
    end else begin
      idx_q <= idx_nxt;
      if (len_we) begin
        len_q <= len_nxt;
      end
    end
  end

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               len_we,
  input  logic [LEN_W-1:0]   len_data,
  input  logic               diff_mode,
  input  logic               acq_en,
  input  logic               adv,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [CH_W-1:0]    mux_sel,
  output logic [GAIN_W-1:0]  gain_sel,
  output logic               ref_half,
  output logic               ref_uni,
  output logic               se_status
);

  logic [IDX_W-1:0] idx_nxt;
  logic [LEN_W-1:0] len_q;
  scan_entry_t      rd_ent;
  scan_entry_t      sel_q;

  scan_seq_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .acq_en   (acq_en),
    .adv      (adv),
    .len_we   (len_we),
    .len_data (len_data),
    .idx_q    (cur_idx),
    .idx_nxt  (idx_nxt),
    .len_q    (len_q)
  );

  // The table is read at the upcoming index, so the select register
  // and the index register change on the same edge.
  scan_seq_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (scan_entry_t'(wr_data)),
    .rd_idx  (idx_nxt),
    .rd_data (rd_ent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= rd_ent;
    end
  end

  always_comb begin
    mux_sel = sel_q.ch;
    if (diff_mode) begin
      mux_sel[CH_W-1] = 1'b0;
    end
  end

  assign gain_sel  = sel_q.gain;
  assign ref_half  = sel_q.half;
  assign ref_uni   = sel_q.uni;
  assign se_status = !diff_mode;

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int LEN_W = 5,
  parameter int CH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_en,
  input logic             adv,
  input logic             diff_mode,
  input logic [IDX_W-1:0] cur_idx,
  input logic [LEN_W-1:0] len_q,
  input logic [CH_W-1:0]  mux_sel
);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> cur_idx == '0);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en && adv && ((LEN_W'(cur_idx) + LEN_W'(1)) < len_q)
    |=> cur_idx == $past(cur_idx) + IDX_W'(1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en && !adv |=> $stable(cur_idx));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en && adv && ((LEN_W'(cur_idx) + LEN_W'(1)) >= len_q)
    |=> cur_idx == '0);

  assert_len_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(DEPTH));

  assert_diff_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    diff_mode |-> !mux_sel[CH_W-1]);

endmodule

bind scan_seq_top scan_seq_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W), .CH_W(scan_seq_pkg::CH_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acq_en    (acq_en),
  .adv       (adv),
  .diff_mode (diff_mode),
  .cur_idx   (cur_idx),
  .len_q     (len_q),
  .mux_sel   (mux_sel)
);

// File: tb/scan_seq_top_tb.sv
module scan_seq_top_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       len_we;
  logic [4:0] len_data;
  logic       diff_mode;
  logic       acq_en;
  logic       adv;
  logic [3:0] cur_idx;
  logic [3:0] mux_sel;
  logic [1:0] gain_sel;
  logic       ref_half;
  logic       ref_uni;
  logic       se_status;

  int n_run;
  int n_fail;
  bit done;

  logic [7:0] m_mem [16];
  int         m_len;
  int         m_idx;
  logic [7:0] m_sel;

  scan_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .len_we(len_we), .len_data(len_data),
    .diff_mode(diff_mode), .acq_en(acq_en), .adv(adv), .cur_idx(cur_idx),
    .mux_sel(mux_sel), .gain_sel(gain_sel), .ref_half(ref_half),
    .ref_uni(ref_uni), .se_status(se_status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mux(input logic [7:0] e, input logic d);
    return d ? int'(e[2:0]) : int'(e[3:0]);
  endfunction

  function automatic int next_idx(input logic a, input logic s);
    if (!a) return 0;
    if (!s) return m_idx;
    return (m_idx + 1 >= m_len) ? 0 : m_idx + 1;
  endfunction

  task automatic check_all(input string req);
    chk({req, " idx"}, int'(cur_idx), m_idx);
    chk("R6 mux", int'(mux_sel), exp_mux(m_sel, diff_mode));
    chk("R7 gain", int'(gain_sel), int'(m_sel[5:4]));
    chk("R7 half", int'(ref_half), int'(m_sel[6]));
    chk("R7 uni", int'(ref_uni), int'(m_sel[7]));
    chk("R8 status", int'(se_status), int'(!diff_mode));
  endtask

  // Called at a falling edge: drive, model the next rising edge, check.
  task automatic step(input logic a, input logic s, input logic we,
                      input logic [3:0] wa, input logic [7:0] wd,
                      input logic lwe, input logic [4:0] ld,
                      input logic d, input string req);
    int ni;
    acq_en = a; adv = s; wr_en = we; wr_addr = wa; wr_data = wd;
    len_we = lwe; len_data = ld; diff_mode = d;
    ni = next_idx(a, s);
    m_sel = m_mem[ni];
    if (we) m_mem[wa] = wd;
    if (lwe) m_len = (int'(ld) > 16) ? 16 : int'(ld);
    m_idx = ni;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; len_we = 1'b0;
    check_all(req);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; len_we = 0;
    len_data = 0; diff_mode = 0; acq_en = 0; adv = 0;
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    m_len = 1; m_idx = 0; m_sel = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R1: the length after reset is 1, so strobes keep the index at 0.
    step(1, 1, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R1");

    // Load the table with distinct values while idle.
    for (int i = 0; i < 16; i++)
      step(0, 0, 1, 4'(i), 8'(i * 37 + 5), 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 5'd4, 0, "R5");
    // R2: strobes are ignored while idle.
    repeat (3) step(0, 1, 0, 0, 0, 0, 0, 0, "R2");
    // R3/R4: stepping and wrap at length 4, with pauses in between.
    for (int i = 0; i < 10; i++)
      step(1, (i % 3) != 2, 0, 0, 0, 0, 0, 0, "R3_R4");
    // R5: a length of 0 pins the index at entry 0.
    step(1, 1, 0, 0, 0, 1, 5'd0, 0, "R5");
    repeat (3) step(1, 1, 0, 0, 0, 0, 0, 0, "R5");
    // R5: a length of 25 saturates to 16, so there is a full 16-entry wrap.
    step(0, 0, 0, 0, 0, 1, 5'd25, 0, "R5");
    for (int i = 0; i < 18; i++)
      step(1, 1, 0, 0, 0, 0, 0, 0, "R5_R4");
    // R6: differential mode with channels 8..15 clears the MSB.
    step(1, 0, 1, 4'(m_idx), 8'hFC, 0, 0, 1, "R6");
    step(1, 0, 0, 0, 0, 0, 0, 1, "R6");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6");
    // R9: a write to the selected entry shows one cycle later.
    step(1, 0, 1, 4'(m_idx), 8'h5A, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R10: dropping acq_en restarts at entry 0.
    step(1, 1, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R10");

    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      logic a, s, we, lwe, d;
      a   = ($urandom % 16) != 0;
      s   = ($urandom % 2) != 0;
      we  = ($urandom % 8) == 0;
      lwe = ($urandom % 40) == 0;
      d   = ($urandom % 10) == 0;
      step(a, s, we, 4'($urandom), 8'($urandom), lwe, 5'($urandom % 20), d,
           "R3_R4_rand");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule